// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a small bank of 32-bit system control words on a word-addressed read/write bus. A software agent changes the ordinary words only after it opens the bank by writing a 16-bit unlock key to a dedicated port. A second 16-bit key, written to another port, closes the bank again. The two key ports are always writable. The bank resets closed.

Each word offset has a fixed access class: read/write, read-only, write-only or unmapped. Illegal accesses raise a registered one-cycle error flag. Read data is registered and appears one cycle after the read strobe. The reset-control word turns an accepted write with bit 0 set into a one-cycle soft-reset request for the surrounding system. The secure-configuration word keeps a single bit and ignores the lock.

Top module: `keyed_ctrl_bank`

## Requirements
- R1: After reset the bank is locked and the words read back their defaults:
  - word 3 (lock status) = 1
  - words 4 and 5 (PLL control) = 0x0001A008
  - word 6 (PLL status) = 0x0000003F
  - word 7 (clock control) = 0x1F000400
  - word 9 (boot mode) = 0x00000001
  - word 10 (ID) = ID_VALUE, default 0x13572468
  - word 12 (pad config) = 0x00001601
  - words 0, 8 and 11 = 0

  Also after reset, `err`, `soft_rst_req` and `rdata` are 0.
- R2: A write to word 2 whose low 16 bits equal 0xDF0D clears the lock status, whatever the upper 16 bits hold. Any other value written there leaves the lock status unchanged.
- R3: A write to word 1 whose low 16 bits equal 0x767B sets the lock status. Any other value written there leaves the lock status unchanged.
- R4: While the bank is locked, a write to a read/write word (4, 5, 7, 8, 11, 12) is discarded, and the word keeps its contents.
- R5: While the bank is unlocked, a write to a read/write word stores all 32 bits. A later read returns that value.
- R6: Word 0 (secure configuration) stores only bit 0 of the written value and reads back zero in bits 31:1. Writes to word 0 take effect whether the bank is locked or not.
- R7: A write to a read-only word (3, 6, 9, 10) or to an unmapped word (13 to 15) changes nothing. It sets `err` high for the one cycle after the write.
- R8: A read of a write-only word (1, 2) or of an unmapped word sets `err` high for the cycle in which `rdata` is valid. The read still returns the stored word, which is 0 for these offsets. A read of a readable word leaves `err` low.
- R9: `soft_rst_req` is high for exactly the one cycle after an accepted write to word 8 with bit 0 set. A write to word 8 with bit 0 clear raises no request. A write to word 8 while the bank is locked raises no request.
- R10: `rdata` changes only on a read, so it holds its value across idle cycles and across writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge (takes priority over rd_en) |
| rd_en | input | 1 | Read strobe, sampled at the rising edge |
| addr | input | 4 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after rd_en |
| err | output | 1 | Registered one-cycle access-error flag |
| soft_rst_req | output | 1 | One-cycle soft-reset request |

## Verification
The key ports are driven with the exact keys, with the keys under changed upper halves, and with near-miss values. This separates a full 16-bit key compare from a 32-bit compare and from no compare at all. Writes to every access class are tried both locked and unlocked, which tells lock-gated storage apart from the lock bypass of the key ports and of the secure word. It also exposes writes that wrongly land on read-only words. A long constrained-random mix of reads, writes and key values, seeded with a fixed seed, follows the directed cases and is scored against a bench model of every word. Dedicated cases cover the soft-reset request with bit 0 set, bit 0 clear and the bank locked.

// File: rtl/keyed_ctrl_pkg.sv
// Shared definitions for the key-locked control bank.
// Holds the word map, the access classes and the reset values.
// Assumes a 16-word map of 32-bit words.
package keyed_ctrl_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 16;
    localparam int ADDR_W    = $clog2(NUM_WORDS);
    localparam int KEY_W     = 16;

    localparam int A_SECURE  = 0;
    localparam int A_LOCK    = 1;
    localparam int A_UNLOCK  = 2;
    localparam int A_LOCKSTA = 3;
    localparam int A_PLL_A   = 4;
    localparam int A_PLL_B   = 5;
    localparam int A_PLLSTAT = 6;
    localparam int A_CLKCTL  = 7;
    localparam int A_RSTCTL  = 8;
    localparam int A_BOOT    = 9;
    localparam int A_ID      = 10;
    localparam int A_SCRATCH = 11;
    localparam int A_PADCFG  = 12;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RO   = 2'd1,
        ACC_WO   = 2'd2,
        ACC_RW   = 2'd3
    } acc_t;

    typedef logic [NUM_WORDS-1:0][WORD_W-1:0] word_arr_t;

    // Access class of a word offset
    function automatic acc_t word_class(input int idx);
        case (idx)
            A_SECURE, A_PLL_A, A_PLL_B, A_CLKCTL,
            A_RSTCTL, A_SCRATCH, A_PADCFG:      return ACC_RW;
            A_LOCK, A_UNLOCK:                   return ACC_WO;
            A_LOCKSTA, A_PLLSTAT, A_BOOT, A_ID: return ACC_RO;
            default:                            return ACC_NONE;
        endcase
    endfunction

    // Fixed value loaded at reset (or held constant for read-only words)
    function automatic logic [WORD_W-1:0] word_default(input int idx);
        case (idx)
            A_PLL_A, A_PLL_B: return 32'h0001_A008;
            A_PLLSTAT:        return 32'h0000_003F;
            A_CLKCTL:         return 32'h1F00_0400;
            A_BOOT:           return 32'h0000_0001;
            A_PADCFG:         return 32'h0000_1601;
            default:          return '0;
        endcase
    endfunction

endpackage

// File: rtl/kcb_attr_decode.sv
// Offset decoder: turns a word offset into its access class and flags for
// the special offsets. Purely combinational, so it adds no latency.
module kcb_attr_decode
    import keyed_ctrl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output acc_t              cls,
    output logic              is_lock,
    output logic              is_unlock,
    output logic              is_secure,
    output logic              is_rstctl
);

    // Look up the class and special-offset flags
    always_comb begin
        cls       = word_class(int'(addr));
        is_lock   = (int'(addr) == A_LOCK);
        is_unlock = (int'(addr) == A_UNLOCK);
        is_secure = (int'(addr) == A_SECURE);
        is_rstctl = (int'(addr) == A_RSTCTL);
    end

endmodule

// File: rtl/kcb_key_unit.sv
// Lock state keeper: compares the low key bits written to the lock or
// unlock port against the two keys. It assumes both ports are never
// decoded at once. The lock state resets to locked.
module kcb_key_unit
    import keyed_ctrl_pkg::*;
#(
    parameter logic [KEY_W-1:0] LOCK_KEY   = 16'h767B,
    parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hDF0D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             is_lock,
    input  logic             is_unlock,
    input  logic [KEY_W-1:0] key,
    output logic             locked
);

    // Update lock state on a matching key write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b1;
        end else if (wr_en && is_lock && key == LOCK_KEY) begin
            locked <= 1'b1;
        end else if (wr_en && is_unlock && key == UNLOCK_KEY) begin
            locked <= 1'b0;
        end
    end

endmodule

// File: rtl/kcb_reg_store.sv
// Word storage: a flop word for each read/write offset, constants for
// read-only offsets, live lock status at its offset and zero elsewhere.
// Assumes we_vec has at most one bit set and already includes the lock
// and class qualification.
module kcb_reg_store
    import keyed_ctrl_pkg::*;
#(
    parameter logic [WORD_W-1:0] ID_VALUE = 32'h1357_2468
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WORDS-1:0] we_vec,
    input  logic [WORD_W-1:0]    wdata,
    input  logic                 locked,
    output word_arr_t            words
);

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        if (word_class(i) == ACC_RW) begin : g_rw
            // Hold a writable word, loading its default at reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    words[i] <= word_default(i);
                end else if (we_vec[i]) begin
                    words[i] <= wdata;
                end
            end
        end else if (i == A_LOCKSTA) begin : g_lsta
            assign words[i] = {{(WORD_W-1){1'b0}}, locked};
        end else if (i == A_ID) begin : g_id
            assign words[i] = ID_VALUE;
        end else begin : g_const
            assign words[i] = word_default(i);
        end
    end

endmodule

// File: rtl/keyed_ctrl_bank.sv
// Key-locked system control register bank (top).
// Decodes each access, qualifies writes with the lock state, stores the
// words, and registers read data, the error flag and the soft-reset
// request. Assumes wr_en takes priority over a simultaneous rd_en.
module keyed_ctrl_bank
    import keyed_ctrl_pkg::*;
#(
    parameter logic [WORD_W-1:0] ID_VALUE   = 32'h1357_2468,
    parameter logic [KEY_W-1:0]  LOCK_KEY   = 16'h767B,
    parameter logic [KEY_W-1:0]  UNLOCK_KEY = 16'hDF0D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              err,
    output logic              soft_rst_req
);

    acc_t                 cls;
    logic                 is_lock, is_unlock, is_secure, is_rstctl;
    logic                 locked;
    logic                 wr_ok;
    logic                 rd_now;
    logic [NUM_WORDS-1:0] we_vec;
    logic [WORD_W-1:0]    store_data;
    word_arr_t            words;

    kcb_attr_decode i_dec (
        .addr      (addr),
        .cls       (cls),
        .is_lock   (is_lock),
        .is_unlock (is_unlock),
        .is_secure (is_secure),
        .is_rstctl (is_rstctl)
    );

    kcb_key_unit #(
        .LOCK_KEY   (LOCK_KEY),
        .UNLOCK_KEY (UNLOCK_KEY)
    ) i_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .is_lock   (is_lock),
        .is_unlock (is_unlock),
        .key       (wdata[KEY_W-1:0]),
        .locked    (locked)
    );

    // Qualify the write and shape its data
    always_comb begin
        wr_ok      = wr_en && (cls == ACC_RW) && (!locked || is_secure);
        rd_now     = rd_en && !wr_en;
        we_vec     = '0;
        we_vec[addr] = wr_ok;
        store_data = is_secure ? {{(WORD_W-1){1'b0}}, wdata[0]} : wdata;
    end

    kcb_reg_store #(
        .ID_VALUE (ID_VALUE)
    ) i_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_vec (we_vec),
        .wdata  (store_data),
        .locked (locked),
        .words  (words)
    );

    // Register the read response, the error flag and the reset request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata        <= '0;
            err          <= 1'b0;
            soft_rst_req <= 1'b0;
        end else begin
            if (rd_now) begin
                rdata <= words[addr];
            end
            err <= (wr_en && !(cls == ACC_RW || cls == ACC_WO)) ||
                   (rd_now && !(cls == ACC_RW || cls == ACC_RO));
            soft_rst_req <= wr_ok && is_rstctl && wdata[0];
        end
    end

endmodule

// File: rtl/kcb_checker.sv
// Property checker for keyed_ctrl_bank, attached by bind. It watches the
// bus ports, the lock state and the stored words.
module kcb_checker
    import keyed_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [WORD_W-1:0] wdata,
    input logic [WORD_W-1:0] rdata,
    input logic              err,
    input logic              soft_rst_req,
    input logic              locked,
    input word_arr_t         words
);

    // R2: correct unlock key opens the bank
    p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) == A_UNLOCK && wdata[15:0] == 16'hDF0D) |=> !locked);

    // R3: correct lock key closes the bank
    p_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) == A_LOCK && wdata[15:0] == 16'h767B) |=> locked);

    // R3: lock state moves only through the key ports
    p_lock_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || (int'(addr) != A_LOCK && int'(addr) != A_UNLOCK)) |=> $stable(locked));

    // R4: locked writes leave every word intact (secure word and unlock excluded)
    p_locked_discard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_en && int'(addr) != A_SECURE && int'(addr) != A_UNLOCK)
        |=> $stable(words));

    // R7: writes to unmapped offsets raise the error flag
    p_unmapped_wr_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) > A_PADCFG) |=> err);

    // R9: a reset request always follows an accepted reset-control write
    p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_req |-> $past(wr_en && int'(addr) == A_RSTCTL && wdata[0] && !locked));

    // R10: read data moves only after a read
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !wr_en) |=> $stable(rdata));

endmodule

bind keyed_ctrl_bank kcb_checker i_kcb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .err          (err),
    .soft_rst_req (soft_rst_req),
    .locked       (locked),
    .words        (words)
);

// File: tb/test_keyed_ctrl_bank.sv
// Bench for keyed_ctrl_bank: directed corner cases, then seeded random
// traffic, all scored against a bench model of the word map.
module test_keyed_ctrl_bank;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;
    logic        soft_rst_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] m_mem [16];
    logic        m_lock;

    keyed_ctrl_bank i_keyed_ctrl_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .err(err), .soft_rst_req(soft_rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // class: 0 unmapped, 1 read-only, 2 write-only, 3 read/write
    function automatic int m_class(input int a);
        if (a == 0 || a == 4 || a == 5 || a == 7 || a == 8 || a == 11 || a == 12) return 3;
        if (a == 1 || a == 2) return 2;
        if (a == 3 || a == 6 || a == 9 || a == 10) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] m_read(input int a);
        case (a)
            3:  return {31'b0, m_lock};
            6:  return 32'h0000_003F;
            9:  return 32'h0000_0001;
            10: return 32'h1357_2468;
            default: return (m_class(a) == 3) ? m_mem[a] : 32'h0;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        m_mem[4] = 32'h0001_A008; m_mem[5] = 32'h0001_A008;
        m_mem[7] = 32'h1F00_0400; m_mem[12] = 32'h0000_1601;
        m_lock = 1'b1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One write; checks err and the reset request one cycle later
    task automatic do_write(input string tag, input int a, input logic [31:0] d);
        logic exp_err, exp_pulse;
        @(negedge clk);
        wr_en = 1'b1; addr = 4'(a); wdata = d;
        exp_err   = !(m_class(a) == 3 || m_class(a) == 2);
        exp_pulse = (a == 8) && !m_lock && d[0];
        if (m_class(a) == 3 && (!m_lock || a == 0)) m_mem[a] = (a == 0) ? {31'b0, d[0]} : d;
        if (a == 1 && d[15:0] == 16'h767B) m_lock = 1'b1;
        else if (a == 2 && d[15:0] == 16'hDF0D) m_lock = 1'b0;
        @(negedge clk);
        check({tag, " err"}, {31'b0, err}, {31'b0, exp_err});
        check({tag, " R9 pulse"}, {31'b0, soft_rst_req}, {31'b0, exp_pulse});
        wr_en = 1'b0;
    endtask

    // One read; checks data and err one cycle later
    task automatic do_read(input string tag, input int a);
        @(negedge clk);
        rd_en = 1'b1; addr = 4'(a);
        @(negedge clk);
        check({tag, " data"}, rdata, m_read(a));
        check({tag, " err"}, {31'b0, err}, {31'b0, m_class(a) == 0 || m_class(a) == 2});
        rd_en = 1'b0;
    endtask

    initial begin
        logic [31:0] held;
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rdata", rdata, 32'h0);
        check("R1 err", {31'b0, err}, 32'h0);
        check("R1 pulse", {31'b0, soft_rst_req}, 32'h0);
        for (int a = 0; a < 13; a++) if (m_class(a) != 2) do_read("R1 default", a);

        // R4: locked write discarded; R9: locked reset-control write, no request
        do_write("R4 locked", 11, 32'hCAFE_F00D);
        do_read("R4 readback", 11);
        do_write("R9 locked", 8, 32'h1);
        do_read("R9 locked readback", 8);
        // R6: secure word keeps bit 0, ignores lock
        do_write("R6 locked", 0, 32'hFFFF_FFFF);
        do_read("R6 readback", 0);
        do_write("R6 clear", 0, 32'hFFFF_FFFE);
        do_read("R6 readback2", 0);
        // R2: wrong key, then key with garbage upper half
        do_write("R2 wrong", 2, 32'h0000_DF0C);
        do_read("R2 still locked", 3);
        do_write("R3 wrong-port", 1, 32'h0000_DF0D);
        do_read("R2 still locked2", 3);
        do_write("R2 key", 2, 32'hABCD_DF0D);
        do_read("R2 unlocked", 3);
        // R5: stored and read back
        do_write("R5 write", 11, 32'h8765_4321);
        do_read("R5 readback", 11);
        do_write("R5 pll", 4, 32'h0000_0000);
        do_read("R5 pll readback", 4);
        // R7: read-only and unmapped writes
        do_write("R7 ro", 6, 32'h0);
        do_read("R7 ro unchanged", 6);
        do_write("R7 lsta", 3, 32'h1);
        do_read("R7 lsta unchanged", 3);
        do_write("R7 unmapped", 14, 32'h5A5A_5A5A);
        do_read("R8 unmapped", 14);
        do_read("R8 wo", 1);
        // R9: request with bit 0 set, none with bit 0 clear
        do_write("R9 set", 8, 32'h0000_0003);
        do_write("R9 clear", 8, 32'h0000_0002);
        // R10: rdata holds across idles and writes
        do_read("R10 setup", 7);
        held = rdata;
        repeat (4) @(negedge clk);
        check("R10 idle hold", rdata, held);
        do_write("R10 write", 12, 32'h1111_2222);
        check("R10 write hold", rdata, held);
        // R3: correct lock key, then writes are discarded
        do_write("R3 bad key", 1, 32'h0000_767A);
        do_read("R3 still open", 3);
        do_write("R3 key", 1, 32'hFFFF_767B);
        do_read("R3 locked", 3);
        do_write("R4 relock", 12, 32'h0);
        do_read("R4 relock readback", 12);

        // Random traffic
        for (int n = 0; n < 600; n++) begin
            int a, k;
            logic [31:0] d;
            a = int'($urandom_range(15));
            k = int'($urandom_range(9));
            d = $urandom();
            if (k == 0) d[15:0] = 16'hDF0D;
            else if (k == 1) d[15:0] = 16'h767B;
            if (k == 2) a = 2;
            if ($urandom_range(1) == 1) do_write("R5 random wr", a, d);
            else do_read("R5 random rd", a);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule